// File: doc/BRIEF.md
# Command Completion Counter with Channel Interrupt

This block keeps the completion bookkeeping for one DMA channel. A hardware-owned counter advances on every completion pulse from the transfer engine. A software-owned counter holds how many of those completions the host has already handled. Both counters are 6 bits wide, wrap modulo 64, and share one status word with an interrupt-active flag that the host clears separately. Their modulo difference is the number of completions still waiting for service. It is also driven out directly as `pending_o`.

A small list-tracking state machine tells the two kinds of completion apart. It has three states: `LS_IDLE` (no list started), `LS_LOADING` (a list has started and its load event has not yet come) and `LS_RUNNING` (the load has been seen). It has three transitions:
- `list_start_i` moves any state to `LS_LOADING`.
- A completion pulse in `LS_LOADING` moves it to `LS_RUNNING`. That pulse counts as the list-load event, not a finished command.
- All other cycles hold the current state.

A load event may raise the interrupt only when the list-interrupt enable is set. A command completion may raise it only when the interrupt enable is set. A configuration bit chooses between a level output and a one-cycle pulse output.

The host uses a simple port. `wr_sel_i`/`rd_sel_i` equal to 0 address the status word and equal to 1 address the general config word. Reads are combinational from the registers. A completion that lands in the same cycle as a host write to the status word is never lost.

Top module: `cmd_done_tracker`

## Requirements
- R1: After reset the done count, processed count and active flag are zero, `irq_o` is low, `pending_o` is 0, and the list tracker is in `LS_IDLE`.
- R2: Each cycle with `evt_i` high advances the done count by one modulo 64 (63 wraps to 0). Cycles without `evt_i` leave it unchanged.
- R3: The status word read (`rd_sel_i`=0) carries the done count in bits [5:0], the active flag in bit 8 and the processed count in bits [21:16]. All other bits read 0.
- R4: A status write (`wr_en_i`=1, `wr_sel_i`=0) loads the processed count from bits [21:16]. The done field of the written word has no effect on the done count.
- R5: A status write with bit 8 = 0 clears the active flag. A status write with bit 8 = 1 leaves it unchanged.
- R6: When `evt_i` coincides with a status write, the done count still advances. If that event is enabled to set the active flag, the flag ends set even if the write cleared it.
- R7: `pending_o` equals (done − processed) mod 64, including when processed is numerically larger than done.
- R8: A config write (`wr_sel_i`=1) stores the full 32-bit word, and a config read (`rd_sel_i`=1) returns it unchanged. Bit 31 is the list-interrupt enable, bit 29 the interrupt enable, and bit 28 selects level (1) or pulse (0) signalling.
- R9: `list_start_i` puts the tracker in `LS_LOADING`. The first `evt_i` in that state is a load event that sets the active flag only when bit 31 is set. Events in `LS_IDLE` or `LS_RUNNING` are command completions that set the flag only when bit 29 is set.
- R10: In level mode `irq_o` equals the active flag ANDed with (bit 29 OR bit 31).
- R11: In pulse mode `irq_o` is high for exactly the one cycle after each enabled event and low otherwise, independent of the active flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | One-cycle completion pulse from the transfer engine |
| list_start_i | input | 1 | Pulse marking that a new command list has been started |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 1 | Write target: 0 status word, 1 config word |
| wr_data_i | input | 32 | Host write data |
| rd_sel_i | input | 1 | Read source: 0 status word, 1 config word |
| rd_data_o | output | 32 | Host read data |
| pending_o | output | 6 | Unhandled completions, (done − processed) mod 64 |
| irq_o | output | 1 | Channel interrupt, level or pulse |

## Verification
The counters are driven with isolated events, a long unbroken run of events that carries the done count past 63, and host writes that place the processed count above the done count. Together these separate correct modulo wrap from saturation or sign errors in `pending_o`. Events that coincide with clearing writes distinguish an event-wins flag from a write-wins flag, and show that the written done field cannot overwrite the counter. A list-start followed by events under each enable bit alone tells the load event apart from ordinary completions. The same event streams are run in level and pulse mode, which separates a held interrupt from a one-cycle pulse.

// File: rtl/cmd_trk_pkg.sv
package cmd_trk_pkg;

    typedef enum logic [1:0] {
        LS_IDLE    = 2'd0,
        LS_LOADING = 2'd1,
        LS_RUNNING = 2'd2
    } list_state_e;

    // status word field positions
    localparam int ST_DONE_LSB  = 0;
    localparam int ST_ACT_BIT   = 8;
    localparam int ST_PROC_LSB  = 16;

    // general config bit positions
    localparam int CF_LEVEL_BIT = 28;
    localparam int CF_IEN_BIT   = 29;
    localparam int CF_LIEN_BIT  = 31;

endpackage

// File: rtl/cmd_cnt_pair.sv
module cmd_cnt_pair #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             proc_we_i,
    input  logic [CNT_W-1:0] proc_wdata_i,
    output logic [CNT_W-1:0] done_o,
    output logic [CNT_W-1:0] proc_o,
    output logic [CNT_W-1:0] pending_o
);

    logic [CNT_W-1:0] done_q;
    logic [CNT_W-1:0] proc_q;

    // hardware side: only events move the done count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= '0;
        end else if (evt_i) begin
            done_q <= done_q + 1'b1;
        end
    end

    // software side: only host writes move the processed count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proc_q <= '0;
        end else if (proc_we_i) begin
            proc_q <= proc_wdata_i;
        end
    end

    assign done_o    = done_q;
    assign proc_o    = proc_q;
    assign pending_o = done_q - proc_q;

    p_done_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_i |=> $stable(done_q));

    p_done_moves_under_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && proc_we_i) |=> (done_q != $past(done_q)));

    p_proc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !proc_we_i |=> $stable(proc_q));

endmodule

// File: rtl/cmd_irq_fsm.sv
module cmd_irq_fsm
    import cmd_trk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic list_start_i,
    input  logic ien_i,
    input  logic lien_i,
    input  logic level_i,
    input  logic clr_i,
    output logic active_o,
    output logic irq_o
);

    list_state_e state_q;
    list_state_e state_d;
    logic        load_evt;
    logic        evt_en;
    logic        active_q;
    logic        pulse_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_IDLE: begin
                if (list_start_i) state_d = LS_LOADING;
            end
            LS_LOADING: begin
                if (list_start_i)  state_d = LS_LOADING;
                else if (evt_i)    state_d = LS_RUNNING;
            end
            LS_RUNNING: begin
                if (list_start_i) state_d = LS_LOADING;
            end
            default: state_d = LS_IDLE;
        endcase
    end

    // event classification
    always_comb begin
        load_evt = evt_i && (state_q == LS_LOADING);
        evt_en   = evt_i && (load_evt ? lien_i : ien_i);
    end

    // active flag: an enabled event outranks a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            pulse_q <= evt_en;
            if (evt_en) begin
                active_q <= 1'b1;
            end else if (clr_i) begin
                active_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        active_o = active_q;
        irq_o    = level_i ? (active_q && (ien_i || lien_i)) : pulse_q;
    end

    p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && ien_i && state_q == LS_RUNNING && clr_i) |=> active_q);

    p_load_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_LOADING && evt_i && !list_start_i) |=> (state_q == LS_RUNNING));

    p_start_enters_loading_r9: assert property (@(posedge clk) disable iff (!rst_n)
        list_start_i |=> (state_q == LS_LOADING));

    p_level_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i && !active_q) |-> !irq_o);

    p_no_spurious_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_i && clr_i) |=> !active_q);

endmodule

// File: rtl/cmd_done_tracker.sv
module cmd_done_tracker
    import cmd_trk_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic              list_start_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_sel_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CNT_W-1:0]  pending_o,
    output logic              irq_o
);

    localparam int PROC_MSB = ST_PROC_LSB + CNT_W - 1;
    localparam int DONE_MSB = ST_DONE_LSB + CNT_W - 1;

    logic [DATA_W-1:0] cfg_q;
    logic              stat_we;
    logic              clr_act;
    logic [CNT_W-1:0]  done_w;
    logic [CNT_W-1:0]  proc_w;
    logic              active_w;
    logic [DATA_W-1:0] status_word;

    assign stat_we = wr_en_i && !wr_sel_i;
    assign clr_act = stat_we && !wr_data_i[ST_ACT_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en_i && wr_sel_i) begin
            cfg_q <= wr_data_i;
        end
    end

    cmd_cnt_pair #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt_i),
        .proc_we_i    (stat_we),
        .proc_wdata_i (wr_data_i[PROC_MSB:ST_PROC_LSB]),
        .done_o       (done_w),
        .proc_o       (proc_w),
        .pending_o    (pending_o)
    );

    cmd_irq_fsm u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt_i),
        .list_start_i (list_start_i),
        .ien_i        (cfg_q[CF_IEN_BIT]),
        .lien_i       (cfg_q[CF_LIEN_BIT]),
        .level_i      (cfg_q[CF_LEVEL_BIT]),
        .clr_i        (clr_act),
        .active_o     (active_w),
        .irq_o        (irq_o)
    );

    always_comb begin
        status_word                       = '0;
        status_word[DONE_MSB:ST_DONE_LSB] = done_w;
        status_word[ST_ACT_BIT]           = active_w;
        status_word[PROC_MSB:ST_PROC_LSB] = proc_w;
        rd_data_o = rd_sel_i ? cfg_q : status_word;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (pending_o == '0 && !active_w));

    p_pending_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && !evt_i && wr_data_i[PROC_MSB:ST_PROC_LSB] == done_w) |=> (pending_o == '0));

endmodule

// File: tb/cmd_done_tracker_bench.sv
module cmd_done_tracker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt = 1'b0, ls = 1'b0, we = 1'b0, wsel = 1'b0, rsel = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic [5:0]  pend;
    logic        irq;

    always #5 clk = ~clk;

    cmd_done_tracker u_cmd_done_tracker (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .list_start_i(ls),
        .wr_en_i(we), .wr_sel_i(wsel), .wr_data_i(wd), .rd_sel_i(rsel),
        .rd_data_o(rd), .pending_o(pend), .irq_o(irq)
    );

    typedef struct {
        logic [31:0] rd;
        logic        irq;
        logic [5:0]  pend;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   finished = 1'b0;

    // reference state
    logic [5:0]  m_done = 0, m_proc = 0;
    logic        m_act = 0;
    logic [31:0] m_cfg = 0;
    int          m_st = 0; // 0 idle, 1 loading, 2 running

    task automatic cyc(input logic e, input logic l, input logic w, input logic s,
                       input logic [31:0] d, input logic r, input string tag);
        logic ld, en, pulse;
        exp_t x;
        @(negedge clk);
        evt = e; ls = l; we = w; wsel = s; wd = d; rsel = r;
        ld = e && (m_st == 1);
        en = e && (ld ? m_cfg[31] : m_cfg[29]);
        if (e) m_done = m_done + 6'd1;
        if (w && !s) begin
            m_proc = d[21:16];
            if (!d[8]) m_act = 1'b0;
        end
        if (en) m_act = 1'b1;
        if (w && s) m_cfg = d;
        pulse = en;
        if (l) m_st = 1;
        else if (ld) m_st = 2;
        x.rd   = r ? m_cfg : {10'b0, m_proc, 7'b0, m_act, 2'b0, m_done};
        x.irq  = m_cfg[28] ? (m_act && (m_cfg[29] || m_cfg[31])) : pulse;
        x.pend = m_done - m_proc;
        x.tag  = tag;
        q.push_back(x);
    endtask

    task automatic idle(input logic r, input string tag);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, r, tag);
    endtask

    task automatic event1(input string tag);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, tag);
    endtask

    task automatic wstat(input logic e, input logic [5:0] p, input logic keep,
                         input logic [5:0] dfield, input string tag);
        cyc(e, 1'b0, 1'b1, 1'b0, {10'b0, p, 7'b0, keep, 2'b0, dfield}, 1'b0, tag);
    endtask

    task automatic wcfg(input logic [31:0] c, input string tag);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, c, 1'b1, tag);
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            checks++;
            if (rd !== x.rd || irq !== x.irq || pend !== x.pend) begin
                fails++;
                $display("FAIL %s: rd=%h irq=%b pend=%0d, expected rd=%h irq=%b pend=%0d",
                         x.tag, rd, irq, pend, x.rd, x.irq, x.pend);
            end
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, both read views
        idle(1'b0, "R1");
        idle(1'b1, "R1");
        // R8 level mode with command interrupt enable
        wcfg(32'h3000_0000, "R8");
        // R2 R10 events raise level interrupt; R3 status layout
        event1("R2");
        event1("R10");
        event1("R3");
        idle(1'b0, "R3");
        // R4 R5 write processed, clear active, done field ignored
        wstat(1'b0, 6'd2, 1'b0, 6'h3F, "R4");
        idle(1'b0, "R5");
        // R6 event in the same cycle as a clearing write
        wstat(1'b1, 6'd3, 1'b0, 6'h00, "R6");
        idle(1'b0, "R6");
        // R5 write with bit 8 set keeps active
        wstat(1'b0, 6'd4, 1'b1, 6'h11, "R5");
        // R8 full config word reads back
        wcfg(32'h3000_00A5, "R8");
        idle(1'b1, "R8");
        // R2 R7 long run wraps the done count past 63
        for (int i = 0; i < 62; i++) event1("R2");
        idle(1'b0, "R7");
        // R7 processed above done
        wstat(1'b0, 6'd60, 1'b0, 6'h00, "R7");
        idle(1'b0, "R7");
        // R9 load event ignored with list interrupt disabled
        wcfg(32'h3000_0000, "R9");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, "R9");
        event1("R9");
        idle(1'b0, "R9");
        event1("R9");
        wstat(1'b0, 6'd0, 1'b0, 6'h00, "R9");
        // R9 list interrupt only: load event sets, command event does not
        wcfg(32'h9000_0000, "R9");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, "R9");
        event1("R9");
        wstat(1'b0, 6'd0, 1'b0, 6'h00, "R9");
        event1("R9");
        idle(1'b0, "R9");
        // R11 pulse mode
        wcfg(32'h2000_0000, "R11");
        event1("R11");
        idle(1'b0, "R11");
        event1("R11");
        event1("R11");
        idle(1'b0, "R11");
        wcfg(32'h0000_0000, "R11");
        event1("R11");
        idle(1'b0, "R11");
        // R10 level mode with list enable alone still forwards a set flag
        wcfg(32'h9000_0000, "R10");
        idle(1'b0, "R10");
        wcfg(32'h1000_0000, "R10");
        idle(1'b0, "R10");
        @(posedge clk);
        #3;
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule